// File: doc/BRIEF.md
# Two-wire serial bus master with fast asymmetric clock

This block is a master for a two-wire serial bus (one clock line, one open-drain data line). It carries out single-register writes and reads on one slave device. The host fills in a slave address, a register index, a data byte and a read/write select, then pulses a start strobe. The block generates the whole bus frame. While the frame runs, `busy` stays high. At the end, `done` pulses for one cycle together with the read data and an acknowledge-error flag.

Every bit slot on the bus is split into four quarters, and a quarter lasts a programmable number of system clocks. Both speed modes use the same frame layout and differ only in the clock waveform. In standard mode the clock is symmetric: it is high for two quarters out of four. In fast mode the clock is high for one quarter and low for three. With a quarter length of one cycle at 25 MHz, or two cycles at 50 MHz, this gives 6.25 MHz at 25 % duty. A longer quarter length slows the bus down.

The data line is modelled as open-drain. `sda_oe` pulls the line low when it is 1. The resolved level of the line comes back on `sda_i`.

Top module: `twm_master`

## Requirements
- R1: During reset and while idle, `scl_o` is 1, `sda_oe` is 0, `busy` is 0 and `done` is 0. After reset, `rdata` and `nack_err` are 0.
- R2: A `cmd_start` pulse is accepted only while `busy` is 0, and `busy` rises on the next cycle. A `cmd_start` that arrives while `busy` is 1 is ignored and does not change the frame in progress.
- R3: A write (`cmd_read`=0) sends a start, then the address byte with bit 0 = 0, then the register byte, then the data byte, then a stop. Each byte goes out MSB first and is followed by an acknowledge slot. At the end of the stop slot, `done` pulses for one cycle with `busy` already 0.
- R4: A read (`cmd_read`=1) sends a start, the address byte with bit 0 = 0 and the register byte. It then sends a repeated start and the address byte with bit 0 = 1. It receives one byte MSB first, answers it with a released (high) acknowledge and sends a stop. The byte appears on `rdata` when `done` pulses.
- R5: The acknowledge is sampled in the last system cycle of the clock-high part of the slot, and low means acknowledged. A high acknowledge after the address byte, the register byte or the write data byte ends the frame with a stop and gives `nack_err`=1 at `done`. No later byte is sent.
- R6: Inside address, register, data and acknowledge slots, the data line changes only while `scl_o` is low. A start is the data line falling while `scl_o` is high, and a stop is the data line rising while `scl_o` is high. A write frame has exactly one start and one stop, and a read frame has two starts and one stop.
- R7: In fast mode (`fast_mode`=1), inside data and acknowledge slots, `scl_o` has a period of 4·D system cycles and is high for D cycles, where D is the quarter length.
- R8: In standard mode (`fast_mode`=0), inside data and acknowledge slots, `scl_o` has a period of 4·D cycles and is high for 2·D cycles.
- R9: The mode and the quarter length are captured when a command is accepted, so changing the inputs during a frame has no effect on it. A quarter length of 0 behaves as 1.
- R10: `nack_err` and `rdata` hold their values from the end of one frame until the next command is accepted. Accepting a command clears `nack_err`.
- R11: The address byte is made of bits [7:6] = parameter `ADDR_HI`, bits [5:4] = `cmd_group`, bits [3:1] = `cmd_dev` and bit 0 = read flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strobe, taken while idle |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_group | input | 2 | Group field of the slave address |
| cmd_dev | input | 3 | Device field of the slave address |
| cmd_reg | input | 8 | Register index |
| cmd_wdata | input | 8 | Byte to write |
| fast_mode | input | 1 | 1 = asymmetric fast clock, 0 = symmetric clock |
| quarter_div | input | DIVW | System cycles per quarter slot (0 acts as 1) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rdata | output | 8 | Byte received by the last read |
| nack_err | output | 1 | The last frame was aborted on a missing acknowledge |
| scl_o | output | 1 | Bus clock |
| sda_oe | output | 1 | 1 = pull the data line low |
| sda_i | input | 1 | Resolved data line level |

## Verification
Some properties are checked on every cycle:
- the bus stays idle when no frame runs;
- the data line is stable while the clock is high inside bit slots;
- start and stop edges happen only while the clock is high;
- in fast mode the clock-high part of a bit slot lasts a single quarter;
- a rejected acknowledge leads straight into a stop slot;
- the captured command, mode and divider stay frozen during a frame.

Other behaviour needs the bench's bus slave to show it:
- whether the frame layout and bit order produce the right register contents and read data;
- the exact clock period and high time measured at the pin;
- that a strobe sent while busy leaves the slave's registers untouched;
- that an error stays visible until the next command.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_ADDR, PH_REG, PH_WDATA,
    PH_RSTART, PH_RADDR, PH_RDATA, PH_STOP
  } phase_t;

  typedef enum logic [1:0] {SL_NONE, SL_START, SL_STOP, SL_BIT} slot_t;

  // Address byte: fixed prefix, group, device, read flag.
  function automatic logic [7:0] addr_byte(input logic [1:0] hi, input logic [1:0] grp,
                                           input logic [2:0] dev, input logic rd);
    return {hi, grp, dev, rd};
  endfunction

  // Clock level for a slot kind in a given quarter.
  function automatic logic scl_level(input slot_t k, input logic [1:0] q, input logic fast);
    case (k)
      SL_START: return (q == 2'd1) || (q == 2'd2);
      SL_STOP:  return (q != 2'd0);
      SL_BIT:   return (q == 2'd2) || (!fast && (q == 2'd1));
      default:  return 1'b1;
    endcase
  endfunction

  // Data line level (1 = released) for a slot kind in a given quarter.
  function automatic logic sda_level(input slot_t k, input logic [1:0] q, input logic bitv);
    case (k)
      SL_START: return (q == 2'd0) || (q == 2'd1);
      SL_STOP:  return (q == 2'd2) || (q == 2'd3);
      SL_BIT:   return bitv;
      default:  return 1'b1;
    endcase
  endfunction

  // Cycles per quarter minus one; a zero setting acts as one.
  function automatic int unsigned quarter_limit(input int unsigned div);
    return (div == 0) ? 0 : div - 1;
  endfunction

endpackage

// File: rtl/twm_qtick.sv
module twm_qtick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div_lim,
  output logic            tick,
  output logic [1:0]      q,
  output logic            slot_end
);
  logic [DIVW-1:0] cnt;

  assign tick     = run && (cnt == div_lim);
  assign slot_end = tick && (q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (!run) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (tick) begin
      cnt <= '0;
      q   <= q + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Quarter counter only moves on a tick while running.
  assert_q_moves_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && $past(run)) |=> (q == $past(q)));
endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
  import twm_pkg::*;
#(
  parameter int         DIVW    = 8,
  parameter logic [1:0] ADDR_HI = 2'b10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_start,
  input  logic            cmd_read,
  input  logic [1:0]      cmd_group,
  input  logic [2:0]      cmd_dev,
  input  logic [7:0]      cmd_reg,
  input  logic [7:0]      cmd_wdata,
  input  logic            fast_mode,
  input  logic [DIVW-1:0] quarter_div,
  input  logic            sda_i,
  input  logic            tick,
  input  logic [1:0]      q,
  input  logic            slot_end,
  output logic            busy,
  output logic            done,
  output logic [7:0]      rdata,
  output logic            nack_err,
  output logic [DIVW-1:0] div_lim,
  output logic            fast_q,
  output slot_t           kind,
  output logic            bitv,
  output logic            nack_seen
);
  phase_t      ph;
  logic [3:0]  bit_idx;
  logic [7:0]  shreg, reg_q, wdata_q;
  logic [1:0]  grp_q;
  logic [2:0]  dev_q;
  logic        rd_q, samp;
  logic        accept, sample_now, in_ack, byte_ph;

  assign busy       = (ph != PH_IDLE);
  assign accept     = cmd_start && !busy;
  assign in_ack     = (bit_idx == 4'd8);
  assign byte_ph    = ph inside {PH_ADDR, PH_REG, PH_WDATA, PH_RADDR, PH_RDATA};
  assign sample_now = tick && (q == 2'd2) && (kind == SL_BIT);
  assign nack_seen  = slot_end && byte_ph && in_ack && (ph != PH_RDATA) && samp;

  always_comb begin
    unique case (ph)
      PH_IDLE:             kind = SL_NONE;
      PH_START, PH_RSTART: kind = SL_START;
      PH_STOP:             kind = SL_STOP;
      default:             kind = SL_BIT;
    endcase
  end

  // Driven bit (1 = released): receive slots and all acknowledge slots release.
  always_comb begin
    if (ph == PH_RDATA || in_ack) bitv = 1'b1;
    else                          bitv = shreg[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      bit_idx  <= 4'd0;
      shreg    <= 8'h00;
      reg_q    <= 8'h00;
      wdata_q  <= 8'h00;
      grp_q    <= 2'd0;
      dev_q    <= 3'd0;
      rd_q     <= 1'b0;
      samp     <= 1'b1;
      div_lim  <= '0;
      fast_q   <= 1'b0;
      done     <= 1'b0;
      rdata    <= 8'h00;
      nack_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sample_now) samp <= sda_i;
      if (accept) begin
        ph       <= PH_START;
        bit_idx  <= 4'd0;
        reg_q    <= cmd_reg;
        wdata_q  <= cmd_wdata;
        grp_q    <= cmd_group;
        dev_q    <= cmd_dev;
        rd_q     <= cmd_read;
        fast_q   <= fast_mode;
        div_lim  <= DIVW'(quarter_limit(int'(quarter_div)));
        nack_err <= 1'b0;
      end else if (slot_end) begin
        unique case (ph)
          PH_START: begin
            ph      <= PH_ADDR;
            shreg   <= addr_byte(ADDR_HI, grp_q, dev_q, 1'b0);
            bit_idx <= 4'd0;
          end
          PH_RSTART: begin
            ph      <= PH_RADDR;
            shreg   <= addr_byte(ADDR_HI, grp_q, dev_q, 1'b1);
            bit_idx <= 4'd0;
          end
          PH_STOP: begin
            ph   <= PH_IDLE;
            done <= 1'b1;
          end
          PH_IDLE: ph <= PH_IDLE;
          default: begin
            if (!in_ack) begin
              shreg   <= {shreg[6:0], samp};
              bit_idx <= bit_idx + 4'd1;
            end else begin
              bit_idx <= 4'd0;
              if (nack_seen) begin
                ph       <= PH_STOP;
                nack_err <= 1'b1;
              end else begin
                unique case (ph)
                  PH_ADDR: begin ph <= PH_REG; shreg <= reg_q; end
                  PH_REG: begin
                    if (rd_q) ph <= PH_RSTART;
                    else begin ph <= PH_WDATA; shreg <= wdata_q; end
                  end
                  PH_RADDR: ph <= PH_RDATA;
                  PH_RDATA: begin ph <= PH_STOP; rdata <= shreg; end
                  default:  ph <= PH_STOP;
                endcase
              end
            end
          end
        endcase
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !busy) |=> busy);
  assert_hold_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(reg_q) && $stable(wdata_q) && $stable(rd_q))));
  assert_hold_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(div_lim) && $stable(fast_q))));
  assert_nack_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen |=> (kind == SL_STOP));
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_start)) |=> ($stable(nack_err) && $stable(rdata)));
endmodule

// File: rtl/twm_master.sv
module twm_master
  import twm_pkg::*;
#(
  parameter int         DIVW    = 8,
  parameter logic [1:0] ADDR_HI = 2'b10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_start,
  input  logic            cmd_read,
  input  logic [1:0]      cmd_group,
  input  logic [2:0]      cmd_dev,
  input  logic [7:0]      cmd_reg,
  input  logic [7:0]      cmd_wdata,
  input  logic            fast_mode,
  input  logic [DIVW-1:0] quarter_div,
  output logic            busy,
  output logic            done,
  output logic [7:0]      rdata,
  output logic            nack_err,
  output logic            scl_o,
  output logic            sda_oe,
  input  logic            sda_i
);
  logic            tick, slot_end, fast_q, bitv, nack_seen;
  logic [1:0]      q;
  logic [DIVW-1:0] div_lim;
  slot_t           kind;

  twm_ctrl #(.DIVW(DIVW), .ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_group(cmd_group), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .fast_mode(fast_mode), .quarter_div(quarter_div),
    .sda_i(sda_i), .tick(tick), .q(q), .slot_end(slot_end),
    .busy(busy), .done(done), .rdata(rdata), .nack_err(nack_err),
    .div_lim(div_lim), .fast_q(fast_q), .kind(kind), .bitv(bitv),
    .nack_seen(nack_seen)
  );

  twm_qtick #(.DIVW(DIVW)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_lim(div_lim),
    .tick(tick), .q(q), .slot_end(slot_end)
  );

  // Pin decode from slot kind and quarter.
  assign scl_o  = scl_level(kind, q, fast_q);
  assign sda_oe = !sda_level(kind, q, bitv);

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe));
  assert_sda_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == SL_BIT) && scl_o && $past(scl_o)) |-> $stable(sda_oe));
  assert_start_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == SL_START) && $rose(sda_oe)) |-> (scl_o && $past(scl_o)));
  assert_stop_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == SL_STOP) && $fell(sda_oe)) |-> (scl_o && $past(scl_o)));
  assert_fast_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q && (kind == SL_BIT) && scl_o && tick) |=> !scl_o);
endmodule

// File: tb/twm_master_bench.sv
module twm_master_bench;
  localparam int DIVW = 8;
  localparam logic [6:0] SLV_ADDR = {2'b10, 2'b01, 3'b101};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_read = 0, fast_mode = 0;
  logic [1:0] cmd_group = 0;
  logic [2:0] cmd_dev = 0;
  logic [7:0] cmd_reg = 0, cmd_wdata = 0;
  logic [DIVW-1:0] quarter_div = 1;
  logic busy, done, nack_err, scl_o, sda_oe;
  logic [7:0] rdata;
  logic slv_pull = 1'b0;
  wire  sda_line = !(sda_oe || slv_pull);

  always #5 clk = ~clk;

  twm_master #(.DIVW(DIVW), .ADDR_HI(2'b10)) u_twm_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_group(cmd_group), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .fast_mode(fast_mode), .quarter_div(quarter_div),
    .busy(busy), .done(done), .rdata(rdata), .nack_err(nack_err),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  int n_checks = 0, n_bad = 0;
  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // ---------------- bus slave model ----------------
  logic [7:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);
  int   nack_byte = -1, n_start = 0, n_stop = 0;
  int   s_cnt = 0, s_byte = 0;
  logic s_act = 0, s_send = 0, s_rw = 0, s_match = 0, s_ack = 0;
  logic ps = 1, pd = 1, s_now, d_now;
  logic [7:0] s_sh = 0, s_ptr = 0, s_tx = 0;

  always @(negedge clk) begin
    s_now = scl_o; d_now = sda_line;
    if (!rst_n) begin
      s_act = 0; s_send = 0; slv_pull = 0;
    end else if (ps && s_now && pd && !d_now) begin
      n_start++; s_act = 1; s_cnt = 0; s_byte = 0; s_send = 0; slv_pull = 0;
    end else if (ps && s_now && !pd && d_now) begin
      n_stop++; s_act = 0; s_send = 0; slv_pull = 0;
    end else if (s_act && !ps && s_now) begin
      if (s_cnt < 8) s_sh = {s_sh[6:0], d_now};
      s_cnt++;
    end else if (s_act && ps && !s_now) begin
      if (s_cnt == 8) begin
        if (s_send) slv_pull = 0;
        else begin
          s_ack = 0;
          if (s_byte == 0) begin
            s_rw = s_sh[0]; s_match = (s_sh[7:1] == SLV_ADDR); s_ack = s_match;
          end else if (s_byte == nack_byte) s_ack = 0;
          else if (s_match && !s_rw) begin
            if (s_byte == 1) s_ptr = s_sh; else mem[s_ptr] = s_sh;
            s_ack = 1;
          end
          slv_pull = s_ack;
        end
      end else if (s_cnt == 9) begin
        s_cnt = 0; slv_pull = 0;
        if (s_send) s_send = 0;
        else if (s_byte == 0 && s_rw && s_match) begin
          s_send = 1; s_tx = mem[s_ptr]; slv_pull = !s_tx[7];
        end
        s_byte++;
      end else if (s_send) slv_pull = !s_tx[7 - s_cnt];
    end
    ps = s_now; pd = d_now;
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit rd; logic [7:0] data; bit nack; } exp_t;
  exp_t exp_q[$];
  exp_t got;

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) check_eq("R3", "unexpected done", 1, 0);
      else begin
        got = exp_q.pop_front();
        check_eq("R3", "busy low at done", int'(busy), 0);
        check_eq("R5", "nack_err at done", int'(nack_err), int'(got.nack));
        if (got.rd && !got.nack) check_eq("R4", "read data", int'(rdata), int'(got.data));
      end
    end
  end

  int st0, sp0;
  task automatic launch(input bit rd, input logic [2:0] dev, input logic [7:0] r,
                        input logic [7:0] wd, input bit fast, input int div,
                        input bit enack, input logic [7:0] edata);
    exp_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    st0 = n_start; sp0 = n_stop;
    cmd_read = rd; cmd_group = 2'b01; cmd_dev = dev; cmd_reg = r; cmd_wdata = wd;
    fast_mode = fast; quarter_div = DIVW'(div); cmd_start = 1;
    it.rd = rd; it.data = edata; it.nack = enack;
    exp_q.push_back(it);
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic finish_txn(input int starts, input string req);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check_eq(req, "start count", n_start - st0, starts);
    check_eq(req, "stop count", n_stop - sp0, 1);
  endtask

  task automatic measure(input int ehi, input int eper, input string req);
    int rises = 0, hi = 1, lo = 0;
    logic prev = scl_o;
    while (rises < 3) begin
      @(negedge clk);
      if (scl_o && !prev) rises++;
      prev = scl_o;
    end
    @(negedge clk);
    while (scl_o) begin hi++; @(negedge clk); end
    while (!scl_o) begin lo++; @(negedge clk); end
    check_eq(req, "scl high cycles", hi, ehi);
    check_eq(req, "scl period", hi + lo, eper);
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    check_eq("R1", "scl in reset", int'(scl_o), 1);
    check_eq("R1", "sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_eq("R1", "busy idle", int'(busy), 0);
    check_eq("R1", "done idle", int'(done), 0);
    check_eq("R1", "nack_err idle", int'(nack_err), 0);
    check_eq("R1", "rdata idle", int'(rdata), 0);

    // R3/R7/R11: fast write, quarter 1 (25 MHz case)
    launch(0, 3'b101, 8'h10, 8'hA5, 1, 1, 0, 8'h00);
    measure(1, 4, "R7");
    finish_txn(1, "R6");
    check_eq("R3", "slave reg written", int'(mem[8'h10]), 8'hA5);
    // R4: read back
    launch(1, 3'b101, 8'h10, 8'h00, 1, 1, 0, 8'hA5);
    finish_txn(2, "R6");
    // R8: standard mode, quarter 3
    launch(0, 3'b101, 8'h33, 8'h3C, 0, 3, 0, 8'h00);
    measure(6, 12, "R8");
    finish_txn(1, "R8");
    launch(1, 3'b101, 8'h33, 8'h00, 0, 3, 0, 8'h3C);
    finish_txn(2, "R4");
    // R7: fast mode, quarter 2 (50 MHz case); untouched register read
    launch(0, 3'b101, 8'h66, 8'h81, 1, 2, 0, 8'h00);
    measure(2, 8, "R7");
    finish_txn(1, "R7");
    launch(1, 3'b101, 8'h44, 8'h00, 1, 2, 0, init_val(8'h44));
    finish_txn(2, "R4");
    // R9: inputs changed mid-frame, and zero quarter length
    launch(0, 3'b101, 8'h70, 8'h12, 1, 1, 0, 8'h00);
    fast_mode = 0; quarter_div = 5;
    measure(1, 4, "R9");
    finish_txn(1, "R9");
    launch(0, 3'b101, 8'h71, 8'h34, 1, 0, 0, 8'h00);
    measure(1, 4, "R9");
    finish_txn(1, "R9");
    // R5/R11: wrong device gets no acknowledge
    launch(0, 3'b100, 8'h72, 8'h56, 1, 1, 1, 8'h00);
    finish_txn(1, "R5");
    check_eq("R5", "no write on wrong device", int'(mem[8'h72]), int'(init_val(8'h72)));
    // R10: error and last read data hold while idle
    repeat (8) @(negedge clk);
    check_eq("R10", "nack_err held", int'(nack_err), 1);
    check_eq("R10", "rdata held", int'(rdata), int'(init_val(8'h44)));
    // R5: slave rejects the data byte
    nack_byte = 2;
    launch(0, 3'b101, 8'h50, 8'h77, 1, 1, 1, 8'h00);
    finish_txn(1, "R5");
    nack_byte = -1;
    launch(1, 3'b101, 8'h50, 8'h00, 1, 1, 0, init_val(8'h50));
    finish_txn(2, "R10");
    // R5: slave rejects the register byte of a read: no repeated start
    nack_byte = 1;
    launch(1, 3'b101, 8'h10, 8'h00, 1, 1, 1, 8'h00);
    finish_txn(1, "R5");
    nack_byte = -1;
    // R2: strobe while busy is ignored
    launch(0, 3'b101, 8'h20, 8'h11, 1, 2, 0, 8'h00);
    repeat (6) @(negedge clk);
    cmd_reg = 8'h21; cmd_wdata = 8'h99; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    finish_txn(1, "R2");
    launch(1, 3'b101, 8'h21, 8'h00, 1, 1, 0, init_val(8'h21));
    finish_txn(2, "R2");
    launch(1, 3'b101, 8'h20, 8'h00, 1, 1, 0, 8'h11);
    finish_txn(2, "R2");
    check_eq("R2", "scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule